// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupts

This block is a peripheral on a 32-bit APB bus that owns a group of general-purpose pins, at most 32 of them. Bit n of every register belongs to pin n. The pin inputs pass through a two-stage synchronizer, and all reads and interrupt decisions use that synchronized copy. Output value and drive enable change only through separate write-ones-to-set and write-ones-to-clear locations, so software never has to do a read-modify-write.

Each pin can raise an interrupt. A pin is either edge triggered or level triggered, and its polarity can be chosen. An extra both-edges bit makes an edge-triggered pin fire on rising and falling edges, whatever its polarity. An edge event stays latched until software acknowledges it. A level condition tracks the synchronized input directly. All enabled status bits combine into a single interrupt line. A loopback bit in the control word routes the output values back into the synchronizer in place of the pads, so the block can test itself.

Top module: `gpio_irq_apb`

## Requirements
- R1: After reset pin_o and pin_oe are all zero, irq_o is low, every interrupt is disabled and level triggered (offset 0x18 reads 0), and polarity is active-high (offset 0x20 reads all ones).
- R2: A write to offset 0x00 sets the pin_o bits that carry a one in the write data. A write to offset 0x04 clears those bits. All other output bits keep their value.
- R3: A write to offset 0x08 sets the matching pin_oe bits and a write to offset 0x0C clears them. Reading either offset returns pin_oe.
- R4: A read of offset 0x00 returns the pin inputs after two clock edges of synchronization. After only one edge it still returns the old value.
- R5: A write to 0x10 enables the interrupts of the marked pins and a write to 0x14 disables them. Either offset reads back the enable mask. irq_o is the OR of all status bits ANDed with their enables.
- R6: A write to 0x18 makes the marked pins edge triggered (mode bit 1). Polarity bit 1, set through 0x20, selects the rising edge. Polarity bit 0, set through 0x24, selects the falling edge. A detected edge latches a status bit, which reads at offset 0x04 and stays set until a one is written to that bit at offset 0x30.
- R7: A write to 0x1C makes the marked pins level triggered. Their status is the synchronized input when polarity is 1 and its inverse when polarity is 0, and it is not latched.
- R8: A write to 0x28 makes an edge-triggered pin fire on both edges regardless of polarity. A write to 0x2C returns it to single-edge behaviour.
- R9: Bit 0 of the control word at 0x34 selects loopback (1) or normal (0). In loopback the synchronizer samples pin_o instead of pin_i.
- R10: pready is always high and pslverr always low. Offsets above 0x34 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and block clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 6 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Error response, always low |
| pin_i | input | NP | Pin inputs from the pads |
| pin_o | output | NP | Pin output values |
| pin_oe | output | NP | Pin drive enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that every APB transfer has a setup phase followed by exactly one access phase. They also assume that paddr and pwdata are stable through the access phase, so one qualified write updates registers on exactly one edge. The bench drives every transfer through tasks that follow that two-phase pattern and change bus signals only on the falling clock edge. Pin inputs are also changed on the falling edge and then held for several cycles, so each edge reaches the detector as one clean transition and is never missed or doubled.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Word index of each register (byte offset divided by four).
    typedef enum logic [3:0] {
        RG_IN_SET   = 4'd0,
        RG_STAT_CLR = 4'd1,
        RG_DIR_OUT  = 4'd2,
        RG_DIR_IN   = 4'd3,
        RG_EN_SET   = 4'd4,
        RG_EN_CLR   = 4'd5,
        RG_EDGE     = 4'd6,
        RG_LEVEL    = 4'd7,
        RG_POL_HI   = 4'd8,
        RG_POL_LO   = 4'd9,
        RG_ANY_SET  = 4'd10,
        RG_ANY_CLR  = 4'd11,
        RG_ACK      = 4'd12,
        RG_CTRL     = 4'd13
    } reg_idx_e;

    localparam int unsigned CTRL_LOOP_BIT = 0;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned NP = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] din,
    output logic [NP-1:0] sync_o,
    output logic [NP-1:0] prev_o
);
    typedef struct packed {
        logic [NP-1:0] meta;
        logic [NP-1:0] sync;
        logic [NP-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = din;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.sync;
    assign prev_o = st_q.prev;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int unsigned NP = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] sync_i,
    input  logic [NP-1:0] prev_i,
    input  logic [NP-1:0] edge_mode_i,
    input  logic [NP-1:0] pol_i,
    input  logic [NP-1:0] any_i,
    input  logic [NP-1:0] ack_i,
    output logic [NP-1:0] status_o
);
    typedef struct packed {
        logic [NP-1:0] lat;
    } det_t;

    det_t st_d, st_q;
    logic [NP-1:0] rise, fall, hit, lvl;

    always_comb begin
        rise = sync_i & ~prev_i;
        fall = ~sync_i & prev_i;
        for (int i = 0; i < NP; i++) begin
            if (any_i[i]) hit[i] = rise[i] | fall[i];
            else          hit[i] = pol_i[i] ? rise[i] : fall[i];
        end
        lvl        = ~(sync_i ^ pol_i);
        st_d       = st_q;
        // a new edge wins over an acknowledge in the same cycle
        st_d.lat   = (st_q.lat & ~ack_i) | (hit & edge_mode_i);
        status_o   = (edge_mode_i & st_q.lat) | (~edge_mode_i & lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.lat & $past(st_q.lat & ~ack_i)) == $past(st_q.lat & ~ack_i))) // R6
        else $error("latched edge lost without acknowledge");

endmodule

// File: rtl/gpio_irq_apb.sv
module gpio_irq_apb
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NP = 32,
    parameter int unsigned AW = 6
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [31:0]   pwdata,
    output logic [31:0]   prdata,
    output logic          pready,
    output logic          pslverr,
    input  logic [NP-1:0] pin_i,
    output logic [NP-1:0] pin_o,
    output logic [NP-1:0] pin_oe,
    output logic          irq_o
);
    localparam int unsigned IDXW = AW - 2;

    typedef struct packed {
        logic [NP-1:0] out;
        logic [NP-1:0] oe;
        logic [NP-1:0] en;
        logic [NP-1:0] edge_m;
        logic [NP-1:0] pol;
        logic [NP-1:0] any;
        logic          loop;
    } cfg_t;

    cfg_t          cfg_d, cfg_q;
    logic          wr_en;
    logic [IDXW-1:0] idx_raw;
    reg_idx_e      idx;
    logic [NP-1:0] wdat, ack, src, sync_v, prev_v, status;

    assign wr_en   = psel & penable & pwrite;
    assign idx_raw = paddr[AW-1:2];
    assign idx     = reg_idx_e'(idx_raw);
    assign wdat    = pwdata[NP-1:0];
    assign src     = cfg_q.loop ? cfg_q.out : pin_i;

    gpio_pin_sync #(.NP(NP)) u_sync (
        .clk    (pclk),
        .rst_n  (presetn),
        .din    (src),
        .sync_o (sync_v),
        .prev_o (prev_v)
    );

    gpio_irq_detect #(.NP(NP)) u_det (
        .clk         (pclk),
        .rst_n       (presetn),
        .sync_i      (sync_v),
        .prev_i      (prev_v),
        .edge_mode_i (cfg_q.edge_m),
        .pol_i       (cfg_q.pol),
        .any_i       (cfg_q.any),
        .ack_i       (ack),
        .status_o    (status)
    );

    always_comb begin
        cfg_d = cfg_q;
        ack   = '0;
        if (wr_en && (idx_raw <= IDXW'(RG_CTRL))) begin
            case (idx)
                RG_IN_SET:   cfg_d.out    = cfg_q.out | wdat;
                RG_STAT_CLR: cfg_d.out    = cfg_q.out & ~wdat;
                RG_DIR_OUT:  cfg_d.oe     = cfg_q.oe | wdat;
                RG_DIR_IN:   cfg_d.oe     = cfg_q.oe & ~wdat;
                RG_EN_SET:   cfg_d.en     = cfg_q.en | wdat;
                RG_EN_CLR:   cfg_d.en     = cfg_q.en & ~wdat;
                RG_EDGE:     cfg_d.edge_m = cfg_q.edge_m | wdat;
                RG_LEVEL:    cfg_d.edge_m = cfg_q.edge_m & ~wdat;
                RG_POL_HI:   cfg_d.pol    = cfg_q.pol | wdat;
                RG_POL_LO:   cfg_d.pol    = cfg_q.pol & ~wdat;
                RG_ANY_SET:  cfg_d.any    = cfg_q.any | wdat;
                RG_ANY_CLR:  cfg_d.any    = cfg_q.any & ~wdat;
                RG_ACK:      ack          = wdat;
                RG_CTRL:     cfg_d.loop   = pwdata[CTRL_LOOP_BIT];
                default:     cfg_d        = cfg_q;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite && (idx_raw <= IDXW'(RG_CTRL))) begin
            case (idx)
                RG_IN_SET:             prdata = 32'(sync_v);
                RG_STAT_CLR:           prdata = 32'(status);
                RG_DIR_OUT, RG_DIR_IN: prdata = 32'(cfg_q.oe);
                RG_EN_SET, RG_EN_CLR:  prdata = 32'(cfg_q.en);
                RG_EDGE, RG_LEVEL:     prdata = 32'(cfg_q.edge_m);
                RG_POL_HI, RG_POL_LO:  prdata = 32'(cfg_q.pol);
                RG_ANY_SET, RG_ANY_CLR: prdata = 32'(cfg_q.any);
                RG_CTRL:               prdata = 32'(cfg_q.loop);
                default:               prdata = '0;
            endcase
        end
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            cfg_q     <= '0;
            cfg_q.pol <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign pin_o   = cfg_q.out;
    assign pin_oe  = cfg_q.oe;
    assign irq_o   = |(status & cfg_q.en);
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    AST_OUT_SET: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_en && idx_raw == IDXW'(RG_IN_SET)) |=>
        ((pin_o & $past(pwdata[NP-1:0])) == $past(pwdata[NP-1:0]))) // R2
        else $error("output set write not applied");

    AST_OUT_CLR: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_en && idx_raw == IDXW'(RG_STAT_CLR)) |=>
        ((pin_o & $past(pwdata[NP-1:0])) == '0)) // R2
        else $error("output clear write not applied");

    AST_OE_SET: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_en && idx_raw == IDXW'(RG_DIR_OUT)) |=>
        ((pin_oe & $past(pwdata[NP-1:0])) == $past(pwdata[NP-1:0]))) // R3
        else $error("direction set write not applied");

    AST_IRQ_GATED: assert property (@(posedge pclk) disable iff (!presetn)
        (cfg_q.en == '0) |-> !irq_o) // R5
        else $error("interrupt raised with all enables off");

    AST_NO_WRITE_HIGH: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_en && idx_raw > IDXW'(RG_CTRL)) |=> ($stable(pin_o) && $stable(pin_oe))) // R10
        else $error("unmapped write changed state");

endmodule

// File: tb/gpio_irq_apb_test.sv
module gpio_irq_apb_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    // each entry: {set mask, clear mask, expected pin_o}
    localparam logic [95:0] VEC [NV] = '{
        {32'h0000_00FF, 32'h0000_0000, 32'h0000_00FF},
        {32'h0000_0000, 32'h0000_000F, 32'h0000_00F0},
        {32'hFFFF_0000, 32'h0000_0000, 32'hFFFF_00F0},
        {32'h0000_0000, 32'h0F0F_00F0, 32'hF0F0_0000},
        {32'h0000_0001, 32'h8000_0000, 32'h70F0_0001},
        {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic        pclk = 0, presetn = 0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [5:0]  paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic        pready, pslverr;
    logic [31:0] pin_i = '0, pin_o, pin_oe;
    logic        irq_o;
    int total = 0, bad = 0;
    bit done = 0;
    logic [31:0] rd;

    gpio_irq_apb uut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .pin_i(pin_i), .pin_o(pin_o),
        .pin_oe(pin_oe), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) pclk = ~pclk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge pclk);
        penable = 1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rdw(input logic [5:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge pclk);
        penable = 1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge pclk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge pclk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1;
        @(negedge pclk); #1;
        // R1 reset state
        chk("R1 pin_o", pin_o, 32'h0);
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 irq_o", 32'(irq_o), 32'h0);
        rdw(6'h10, rd); chk("R1 enable", rd, 32'h0);
        rdw(6'h18, rd); chk("R1 mode", rd, 32'h0);
        rdw(6'h20, rd); chk("R1 polarity", rd, 32'hFFFF_FFFF);

        // R2 output set/clear vectors
        for (int i = 0; i < NV; i++) begin
            wr(6'h00, VEC[i][95:64]);
            wr(6'h04, VEC[i][63:32]);
            #1 chk("R2 pin_o", pin_o, VEC[i][31:0]);
        end

        // R3 direction
        wr(6'h08, 32'h0000_00FF);
        #1 chk("R3 oe set", pin_oe, 32'h0000_00FF);
        wr(6'h0C, 32'h0000_000F);
        rdw(6'h0C, rd); chk("R3 oe read", rd, 32'h0000_00F0);

        // R4 two-edge synchronization
        @(negedge pclk);
        pin_i = 32'hA5A5_0000; psel = 1; pwrite = 0; paddr = 6'h00;
        @(posedge pclk); #1 chk("R4 one edge", prdata, 32'h0);
        @(posedge pclk); #1 chk("R4 two edges", prdata, 32'hA5A5_0000);
        @(negedge pclk); psel = 0;
        pin_i = '0;
        settle();

        // R6 rising edge latch on pin 3
        wr(6'h18, 32'h8);
        wr(6'h10, 32'h8);
        rdw(6'h14, rd); chk("R5 enable read", rd, 32'h8);
        @(negedge pclk); pin_i[3] = 1; settle();
        chk("R6 rise irq", 32'(irq_o), 32'h1);
        @(negedge pclk); pin_i[3] = 0; settle();
        rdw(6'h04, rd); chk("R6 latched status", rd, 32'h8);
        wr(6'h30, 32'h8); #1;
        chk("R6 ack clears", 32'(irq_o), 32'h0);
        // falling polarity
        wr(6'h24, 32'h8);
        @(negedge pclk); pin_i[3] = 1; settle();
        chk("R6 no irq on rise when falling", 32'(irq_o), 32'h0);
        @(negedge pclk); pin_i[3] = 0; settle();
        chk("R6 fall irq", 32'(irq_o), 32'h1);
        wr(6'h30, 32'h8);

        // R8 both edges
        wr(6'h28, 32'h8);
        @(negedge pclk); pin_i[3] = 1; settle();
        chk("R8 rise with both-edges", 32'(irq_o), 32'h1);
        wr(6'h30, 32'h8); #1;
        chk("R8 cleared", 32'(irq_o), 32'h0);
        @(negedge pclk); pin_i[3] = 0; settle();
        chk("R8 fall with both-edges", 32'(irq_o), 32'h1);
        wr(6'h30, 32'h8);
        wr(6'h2C, 32'h8);
        @(negedge pclk); pin_i[3] = 1; settle();
        chk("R8 override removed", 32'(irq_o), 32'h0);
        @(negedge pclk); pin_i[3] = 0; settle();
        wr(6'h30, 32'h8); #1;
        chk("R8 final clear", 32'(irq_o), 32'h0);

        // R7 level on pin 5
        wr(6'h1C, 32'h20);
        wr(6'h20, 32'h20);
        wr(6'h10, 32'h20);
        @(negedge pclk); pin_i[5] = 1; settle();
        chk("R7 level high", 32'(irq_o), 32'h1);
        @(negedge pclk); pin_i[5] = 0; settle();
        chk("R7 not latched", 32'(irq_o), 32'h0);
        wr(6'h24, 32'h20); #1;
        chk("R7 active low", 32'(irq_o), 32'h1);
        wr(6'h14, 32'h20); #1;
        chk("R5 disable", 32'(irq_o), 32'h0);

        // R10 response and unmapped offsets
        chk("R10 pready/pslverr", {30'd0, pready, pslverr}, 32'h2);
        wr(6'h3C, 32'hFFFF_FFFF); #1;
        chk("R10 unmapped write pin_o", pin_o, 32'h0);
        chk("R10 unmapped write pin_oe", pin_oe, 32'h0000_00F0);
        rdw(6'h38, rd); chk("R10 unmapped read", rd, 32'h0);

        // R9 loopback
        pin_i = 32'h0000_0F00;
        wr(6'h34, 32'h1);
        wr(6'h00, 32'h1234_0000);
        settle();
        rdw(6'h00, rd); chk("R9 loopback input", rd, 32'h1234_0000);
        rdw(6'h34, rd); chk("R9 control read", rd, 32'h1);
        wr(6'h34, 32'h0);
        settle();
        rdw(6'h00, rd); chk("R9 normal input", rd, 32'h0000_0F00);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule